// File: doc/BRIEF.md
# Multi-Counter Peak Capture Unit

The unit watches four free-running 5-bit detector counters and turns them into four read-only byte registers. Normally each byte shows its own counter live. A 3-bit command, written through a write strobe, can select one counter for peak capture. The byte of the selected counter then shows the largest value, or the smallest value, that the counter has reached since the compare value was last reset. The other three bytes keep showing their live counters.

The same command field resets the compare value and picks the tracking direction. The live-readback command clears the compare value to zero and selects maximum tracking. A second command presets the compare value to all ones and selects minimum tracking. The usual sequence is to write a reset command first and then a capture command. Software then reads the byte of the selected counter to get the extreme value seen so far.

Top module: `peak_capture_unit`

## Requirements
- R1: After reset, all four bytes show their live counters, the compare value is 0x00 and maximum tracking is selected.
- R2: Writing command 000 clears the compare value to 0x00, selects maximum tracking and returns all four bytes to live readback.
- R3: Writing command 001, 010, 011 or 100 selects counter 0, 1, 2 or 3 for capture. From the next cycle that counter's byte shows the compare value, and the other three bytes show their live counters.
- R4: In maximum tracking, on every clock edge without an accepted command, the compare value takes the selected counter's value if that value is strictly greater.
- R5: Writing command 101 sets the compare value to 0x1F and selects minimum tracking, and leaves the capture selection unchanged.
- R6: In minimum tracking, on every clock edge without an accepted command, the compare value takes the selected counter's value if that value is strictly smaller.
- R7: Writing command 110 or 111 has no effect. Selection, direction and compare value stay as they were, and tracking continues on that edge.
- R8: Byte i (bits 8i+7:8i of the readback bus) holds counter i (bits 5i+4:5i of the counter bus) or the compare value in bits 4:0, and bits 7:5 always read zero.
- R9: An accepted command takes effect on the edge where it is written, and no tracking takes place on that edge. A capture command written while the counter is above the compare value does not load the counter on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_flat | input | 20 | Four 5-bit counter values, counter i at bits 5i+4:5i |
| cmd_wr | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | 3 | Command code |
| rd_bytes | output | 32 | Four readback bytes, byte i at bits 8i+7:8i |

## Verification
A wrong selection register shows up in the cycle right after a capture command: a byte other than the intended one stops following its live counter. A wrong tracking direction, or a wrong compare, shows up in the selected byte on the edge after the counter moves past the stored extreme. So a sweep that drives the counter above and below the stored value exposes it within one or two cycles. A wrong preset or clear shows up as soon as a capture byte is read after 000 or 101. A reserved command that disturbs the state shows up as a changed or stalled value in the selected byte on the following cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_LIVE    = 3'd0,
    CMD_CAP0    = 3'd1,
    CMD_CAP1    = 3'd2,
    CMD_CAP2    = 3'd3,
    CMD_CAP3    = 3'd4,
    CMD_MINRST  = 3'd5,
    CMD_RSVD6   = 3'd6,
    CMD_RSVD7   = 3'd7
  } pcu_cmd_e;

  typedef enum logic {
    TRACK_MAX = 1'b0,
    TRACK_MIN = 1'b1
  } track_mode_e;

endpackage

// File: rtl/pcu_cmd_decode.sv
module pcu_cmd_decode
  import pcu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             do_live,
  output logic             do_capture,
  output logic [IDX_W-1:0] capture_idx,
  output logic             do_minrst,
  output logic             accepted
);

  logic [CMD_W-1:0] idx_full;

  always_comb begin
    do_live     = 1'b0;
    do_capture  = 1'b0;
    do_minrst   = 1'b0;
    idx_full    = cmd_data - CMD_W'(1);
    capture_idx = idx_full[IDX_W-1:0];
    if (cmd_wr) begin
      if (cmd_data == CMD_LIVE) begin
        do_live = 1'b1;
      end else if (cmd_data == CMD_MINRST) begin
        do_minrst = 1'b1;
      end else if (int'(cmd_data) <= NUM_CNT) begin
        do_capture = 1'b1;
      end
    end
    accepted = do_live | do_capture | do_minrst;
  end

endmodule

// File: rtl/pcu_capture_ctrl.sv
module pcu_capture_ctrl
  import pcu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_live,
  input  logic             do_capture,
  input  logic [IDX_W-1:0] capture_idx,
  input  logic             do_minrst,
  input  logic             accepted,
  output logic             cap_active,
  output logic [IDX_W-1:0] cap_sel,
  output track_mode_e      mode,
  output logic             track_en
);

  logic             act_q, act_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  track_mode_e      mode_q, mode_d;
  logic             ctrl_en;

  always_comb begin
    act_d  = act_q;
    sel_d  = sel_q;
    mode_d = mode_q;
    if (do_live) begin
      act_d  = 1'b0;
      mode_d = TRACK_MAX;
    end else if (do_capture) begin
      act_d  = 1'b1;
      sel_d  = capture_idx;
    end else if (do_minrst) begin
      mode_d = TRACK_MIN;
    end
    ctrl_en = accepted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sel_q  <= '0;
      mode_q <= TRACK_MAX;
    end else if (ctrl_en) begin
      act_q  <= act_d;
      sel_q  <= sel_d;
      mode_q <= mode_d;
    end
  end

  assign cap_active = act_q;
  assign cap_sel    = sel_q;
  assign mode       = mode_q;
  assign track_en   = act_q & ~accepted;

  AST_IGNORE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    !accepted |=> ($stable(act_q) && $stable(sel_q) && $stable(mode_q))); // R7

  AST_LIVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    do_live |=> (!act_q && mode_q == TRACK_MAX)); // R2

  AST_MINRST_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    do_minrst |=> (mode_q == TRACK_MIN && $stable(sel_q) && $stable(act_q))); // R5

endmodule

// File: rtl/pcu_peak_tracker.sv
module pcu_peak_tracker
  import pcu_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_zero,
  input  logic             load_full,
  input  logic             track_en,
  input  track_mode_e      mode,
  input  logic [CNT_W-1:0] sample,
  output logic [CNT_W-1:0] peak
);

  logic [CNT_W-1:0] peak_q, peak_d;
  logic             peak_en;
  logic             above, below;

  always_comb begin
    above   = sample > peak_q;
    below   = sample < peak_q;
    peak_d  = peak_q;
    if (load_zero) begin
      peak_d = '0;
    end else if (load_full) begin
      peak_d = '1;
    end else if (track_en) begin
      if (mode == TRACK_MAX && above) begin
        peak_d = sample;
      end else if (mode == TRACK_MIN && below) begin
        peak_d = sample;
      end
    end
    peak_en = load_zero | load_full | track_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
    end else if (peak_en) begin
      peak_q <= peak_d;
    end
  end

  assign peak = peak_q;

  AST_MAX_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && !load_zero && !load_full && mode == TRACK_MAX) |=> peak_q >= $past(peak_q)); // R4

  AST_MAX_TAKES_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && !load_zero && !load_full && mode == TRACK_MAX && sample > peak_q)
      |=> peak_q == $past(sample)); // R4

  AST_MIN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && !load_zero && !load_full && mode == TRACK_MIN) |=> peak_q <= $past(peak_q)); // R6

  AST_MIN_TAKES_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && !load_zero && !load_full && mode == TRACK_MIN && sample < peak_q)
      |=> peak_q == $past(sample)); // R6

  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_zero |=> peak_q == '0); // R2

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_full |=> peak_q == '1); // R5

endmodule

// File: rtl/pcu_readback_mux.sv
module pcu_readback_mux #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 5,
  parameter int BYTE_W  = 8,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int PAD_W  = BYTE_W - CNT_W
) (
  input  logic [NUM_CNT*CNT_W-1:0]  cnt_flat,
  input  logic                      cap_active,
  input  logic [IDX_W-1:0]          cap_sel,
  input  logic [CNT_W-1:0]          peak,
  output logic [NUM_CNT*BYTE_W-1:0] rd_bytes
);

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_slot
    logic             show_peak;
    logic [CNT_W-1:0] slot_val;
    assign show_peak = cap_active && (int'(cap_sel) == gi);
    assign slot_val  = show_peak ? peak : cnt_flat[gi*CNT_W +: CNT_W];
    assign rd_bytes[gi*BYTE_W +: BYTE_W] = {{PAD_W{1'b0}}, slot_val};
  end

endmodule

// File: rtl/peak_capture_unit.sv
module peak_capture_unit
  import pcu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 5,
  parameter int BYTE_W  = 8,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int PAD_W  = BYTE_W - CNT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CNT*CNT_W-1:0]  cnt_flat,
  input  logic                      cmd_wr,
  input  logic [CMD_W-1:0]          cmd_data,
  output logic [NUM_CNT*BYTE_W-1:0] rd_bytes
);

  logic             rst_s0, rst_s1;
  logic             rst_sync_n;
  logic             do_live, do_capture, do_minrst, accepted;
  logic [IDX_W-1:0] capture_idx;
  logic             cap_active, track_en;
  logic [IDX_W-1:0] cap_sel;
  track_mode_e      mode;
  logic [CNT_W-1:0] sample, peak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_sync_n = rst_s1;

  pcu_cmd_decode #(.NUM_CNT(NUM_CNT)) u_dec (
    .cmd_wr     (cmd_wr),
    .cmd_data   (cmd_data),
    .do_live    (do_live),
    .do_capture (do_capture),
    .capture_idx(capture_idx),
    .do_minrst  (do_minrst),
    .accepted   (accepted)
  );

  pcu_capture_ctrl #(.NUM_CNT(NUM_CNT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .do_live    (do_live),
    .do_capture (do_capture),
    .capture_idx(capture_idx),
    .do_minrst  (do_minrst),
    .accepted   (accepted),
    .cap_active (cap_active),
    .cap_sel    (cap_sel),
    .mode       (mode),
    .track_en   (track_en)
  );

  always_comb begin
    sample = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (int'(cap_sel) == i) sample = cnt_flat[i*CNT_W +: CNT_W];
    end
  end

  pcu_peak_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_zero(do_live),
    .load_full(do_minrst),
    .track_en (track_en),
    .mode     (mode),
    .sample   (sample),
    .peak     (peak)
  );

  pcu_readback_mux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_mux (
    .cnt_flat  (cnt_flat),
    .cap_active(cap_active),
    .cap_sel   (cap_sel),
    .peak      (peak),
    .rd_bytes  (rd_bytes)
  );

  logic [NUM_CNT-1:0] slot_differs;
  logic [NUM_CNT-1:0] slot_pad_set;
  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      slot_differs[i] = rd_bytes[i*BYTE_W +: CNT_W] != cnt_flat[i*CNT_W +: CNT_W];
      slot_pad_set[i] = |rd_bytes[i*BYTE_W+CNT_W +: PAD_W];
    end
  end

  AST_ONE_SLOT_PEAK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(slot_differs)); // R3

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    slot_pad_set == '0); // R8

  AST_LIVE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_wr && cmd_data == CMD_LIVE) |=> slot_differs == '0); // R2

endmodule

// File: tb/peak_capture_unit_tb.sv
module peak_capture_unit_tb;

  localparam int NC = 4;
  localparam int CW = 5;
  localparam int BW = 8;

  logic            clk;
  logic            rst_n;
  logic [NC*CW-1:0] cnt_flat;
  logic            cmd_wr;
  logic [2:0]      cmd_data;
  logic [NC*BW-1:0] rd_bytes;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit m_act;
  int m_sel;
  bit m_min;
  int m_peak;

  peak_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_flat(cnt_flat),
    .cmd_wr(cmd_wr), .cmd_data(cmd_data), .rd_bytes(rd_bytes)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_slots(input string tag);
    for (int i = 0; i < NC; i++) begin
      int exp;
      int got;
      string t;
      exp = (m_act && m_sel == i) ? m_peak : int'(cnt_flat[i*CW +: CW]);
      got = int'(rd_bytes[i*BW +: BW]);
      if (tag != "") t = tag;
      else if (m_act && m_sel == i) t = m_min ? "R6" : "R4";
      else t = "R3";
      total++;
      if (got != exp) begin
        bad++;
        $display("FAIL %s slot%0d got=%02h exp=%02h", t, i, got, exp);
      end
      total++;
      if (rd_bytes[i*BW+CW +: BW-CW] != '0) begin
        bad++;
        $display("FAIL R8 slot%0d upper got=%0h exp=0", i, rd_bytes[i*BW+CW +: BW-CW]);
      end
    end
  endtask

  task automatic step(input bit wr, input int c, input int v0, input int v1,
                      input int v2, input int v3, input string tag);
    int vals [NC];
    vals[0] = v0; vals[1] = v1; vals[2] = v2; vals[3] = v3;
    cmd_wr   = wr;
    cmd_data = 3'(c);
    for (int i = 0; i < NC; i++) cnt_flat[i*CW +: CW] = CW'(vals[i] % 32);
    @(posedge clk);
    if (wr && c <= 5) begin
      if (c == 0) begin m_act = 0; m_min = 0; m_peak = 0; end
      else if (c == 5) begin m_min = 1; m_peak = 31; end
      else begin m_act = 1; m_sel = c - 1; end
    end else if (m_act) begin
      int s;
      s = vals[m_sel] % 32;
      if (!m_min && s > m_peak) m_peak = s;
      if (m_min && s < m_peak) m_peak = s;
    end
    @(negedge clk);
    cmd_wr = 1'b0;
    check_slots(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_data = '0; cnt_flat = '0;
    m_act = 0; m_sel = 0; m_min = 0; m_peak = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, live readback of distinct values
    for (int k = 0; k < 6; k++) step(0, 0, 3 + k, 9 + k, 17 + k, 30 - k, "R1");

    for (int sel = 0; sel < NC; sel++) begin
      step(1, 0, 1, 2, 3, 4, "R2");
      // R9: capture command written while counter is high; not loaded on that edge
      step(1, sel + 1, 20, 21, 22, 23, "R9");
      // R4: max sweep
      for (int k = 0; k < 40; k++)
        step(0, 0, (k*11 + sel*5) % 32, (k*13 + 1) % 32, (k*7 + 3) % 32, (k*5 + 9) % 32, "");
      // R7: reserved writes mid-capture, tracking continues
      step(1, 6, 31, 31, 31, 31, "R7");
      step(1, 7, 0, 0, 0, 0, "R7");
      // R5: preset to 0x1F, min tracking, selection kept
      step(1, 5, 2, 2, 2, 2, "R5");
      step(0, 0, 25, 25, 25, 25, "R5");
      // R6: min sweep
      for (int k = 0; k < 40; k++)
        step(0, 0, 31 - (k*3 + sel) % 32, 31 - (k*9) % 32, (k*17) % 32, 31 - k % 32, "");
      step(1, 6, 0, 0, 0, 0, "R7");
      // R3: switch selection directly, peak retained
      step(1, ((sel + 1) % NC) + 1, 1, 1, 1, 1, "R3");
      for (int k = 0; k < 8; k++) step(0, 0, k, 31 - k, k * 3, 15, "");
    end
    step(1, 0, 5, 6, 7, 8, "R2");
    step(0, 0, 8, 7, 6, 5, "R2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule